// File: doc/BRIEF.md
# Standby Mode Controller

This block decides when a small microcontroller's CPU clock and oscillators may stop and when they come back. The CPU raises a one-cycle wait-for-interrupt request together with a mode choice: light sleep, which only gates the CPU clock, or deep sleep, which also shuts down both high-speed oscillators. The controller drives enable lines for the CPU clock gate and for the crystal, internal high-speed, subsystem and low-speed oscillators, and it reports the current mode on a two-bit status output.

Any enabled interrupt ends either standby mode. Leaving deep sleep includes a stabilization wait before the CPU clock returns. When the main clock is the crystal, the wait lasts a programmable power-of-two number of crystal cycles, counted on a crystal-tick strobe. When the main clock is the internal oscillator, the wait is a fixed number of system cycles. Deep sleep is refused while the CPU runs from the subsystem clock, and such a request falls back to light sleep. The controller only gates clocks. It never resets anything, so registers and port latches keep their state.

Top module: `standby_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, status is 00, `cpu_clk_en`=1, `lsosc_en`=1, `hiosc_en`=1, `hxosc_en`=0 and `subosc_en`=0. In run mode the three oscillator enables follow `run_hx_on`, `run_hi_on` and `run_sub_on`.
- R2: A `wfi_req` with `deep_sel`=0 and no enabled interrupt enters sleep on the next edge. In sleep, status is 01, `cpu_clk_en`=0, and the crystal, internal high-speed and subsystem enables keep their run-mode request values.
- R3: A `wfi_req` with `deep_sel`=1 and `cpu_on_sub`=0 enters deep sleep. In deep sleep, status is 10, `cpu_clk_en`=0, `hxosc_en`=0 and `hiosc_en`=0, and `subosc_en` follows `run_sub_on`.
- R4: A `wfi_req` with `deep_sel`=1 while `cpu_on_sub`=1 enters sleep (status 01), and the high-speed enables stay as requested.
- R5: In sleep and in deep sleep, `lsosc_en` equals `lsosc_keep`. In every other mode it is 1.
- R6: An interrupt counts as a wake event only when some bit is set in both `irq_req` and `irq_en`. A requested but disabled interrupt does not end sleep. In sleep, a wake event gives one resume cycle (status 11, `cpu_clk_en`=1), followed by run mode (status 00).
- R7: A wake from deep sleep with a crystal main clock shows status 11 with `cpu_clk_en`=0 and `hxosc_en`=1. This lasts until exactly 2^N crystal ticks have been sampled, where N is `stab_exp`. Then one resume cycle follows, then run mode.
- R8: A wake from deep sleep with an internal main clock waits exactly INT_WAIT (8) cycles with `hiosc_en`=1, whatever `xtal_tick` does. Then one resume cycle follows, then run mode.
- R9: A `wfi_req` that arrives in the same cycle as a wake event is dropped. Status stays 00 and `cpu_clk_en` stays 1.
- R10: `main_is_xtal` and `stab_exp` are captured when deep sleep is entered. Changing them during deep sleep does not change the wake wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi_req | input | 1 | One-cycle wait-for-interrupt request from the CPU |
| deep_sel | input | 1 | 1 requests deep sleep, 0 requests sleep |
| cpu_on_sub | input | 1 | CPU currently clocked from the subsystem clock |
| main_is_xtal | input | 1 | Main clock is the external crystal (0: internal high-speed) |
| lsosc_keep | input | 1 | Keep the low-speed oscillator running in standby |
| stab_exp | input | EXP_W | Crystal wait exponent N (wait of 2^N ticks) |
| run_hx_on | input | 1 | Run-mode request for the crystal oscillator |
| run_hi_on | input | 1 | Run-mode request for the internal high-speed oscillator |
| run_sub_on | input | 1 | Run-mode request for the subsystem oscillator |
| irq_req | input | IRQ_W | Interrupt request lines |
| irq_en | input | IRQ_W | Interrupt enable mask |
| xtal_tick | input | 1 | Strobe, one per crystal cycle |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| hxosc_en | output | 1 | Crystal oscillator enable |
| hiosc_en | output | 1 | Internal high-speed oscillator enable |
| subosc_en | output | 1 | Subsystem oscillator enable |
| lsosc_en | output | 1 | Low-speed internal oscillator enable |
| mode_stat | output | 2 | Mode: 00 run, 01 sleep, 10 deep sleep, 11 waking |

## Verification
The bench sweeps every combination of oscillator requests and the low-speed keep bit through sleep. A design that leaked the deep-sleep shutdown into sleep, or ignored the keep bit, would show the wrong enables. Deep sleep is swept over all eight wait exponents, both main-clock types and two crystal tick rates. The bench counts the wait cycles and the sampled ticks, so an off-by-one counter or a wait that counts system cycles instead of ticks gives a wrong count. Further directed cases cover these corners:
- A deep request from the subsystem clock must not stop the high-speed oscillators.
- A request that coincides with an interrupt must leave the CPU running.
- A masked interrupt must not wake the block.
- Settings changed during deep sleep must not stretch or shorten the wait.

// File: rtl/standby_pkg.sv
package standby_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_DEEP   = 3'd2,
    ST_WAIT   = 3'd3,
    ST_RESUME = 3'd4
  } sb_state_t;

  localparam logic [1:0] STAT_RUN   = 2'b00;
  localparam logic [1:0] STAT_SLEEP = 2'b01;
  localparam logic [1:0] STAT_DEEP  = 2'b10;
  localparam logic [1:0] STAT_WAKE  = 2'b11;
endpackage

// File: rtl/standby_fsm.sv
module standby_fsm
  import standby_pkg::*;
#(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wfi_req,
  input  logic             deep_sel,
  input  logic             cpu_on_sub,
  input  logic             main_is_xtal,
  input  logic [EXP_W-1:0] stab_exp,
  input  logic             wake_evt,
  input  logic             wait_done,
  output sb_state_t        state,
  output sb_state_t        state_nx,
  output logic             wake_xtal_q,
  output logic [EXP_W-1:0] exp_q,
  output logic             timer_start
);

  always_comb begin
    state_nx    = state;
    timer_start = 1'b0;
    case (state)
      ST_RUN: begin
        if (wfi_req && !wake_evt)
          state_nx = (deep_sel && !cpu_on_sub) ? ST_DEEP : ST_SLEEP;
      end
      ST_SLEEP:  if (wake_evt) state_nx = ST_RESUME;
      ST_DEEP: begin
        if (wake_evt) begin
          state_nx    = ST_WAIT;
          timer_start = 1'b1;
        end
      end
      ST_WAIT:   if (wait_done) state_nx = ST_RESUME;
      ST_RESUME: state_nx = ST_RUN;
      default:   state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_RUN;
      wake_xtal_q <= 1'b0;
      exp_q       <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_RUN && state_nx == ST_DEEP) begin
        wake_xtal_q <= main_is_xtal;
        exp_q       <= stab_exp;
      end
    end
  end

  // R4: a deep request made from the subsystem clock becomes sleep
  assert_deep_refused_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && wfi_req && deep_sel && cpu_on_sub && !wake_evt) |=> state == ST_SLEEP);

  // R9: a request that coincides with a wake event is dropped
  assert_abort_entry_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && wfi_req && wake_evt) |=> state == ST_RUN);

  // R6: a wake event in sleep leads to the resume cycle
  assert_sleep_wake_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLEEP && wake_evt) |=> state == ST_RESUME);

  // R10: the captured wake settings hold outside run mode
  assert_cfg_held_R10: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RUN) |=> ($stable(exp_q) && $stable(wake_xtal_q)));

endmodule

// File: rtl/standby_stab_timer.sv
module standby_stab_timer #(
  parameter int EXP_W    = 3,
  parameter int INT_WAIT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             use_xtal,
  input  logic [EXP_W-1:0] exp_sel,
  input  logic             xtal_tick,
  output logic             done
);
  localparam int XT_MAX = 1 << ((1 << EXP_W) - 1);
  localparam int T_MAX  = (XT_MAX > INT_WAIT) ? XT_MAX : INT_WAIT;
  localparam int CNT_W  = $clog2(T_MAX) + 1;

  logic             active;
  logic             use_x_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target_q;
  logic             inc;

  assign inc  = active && (use_x_q ? xtal_tick : 1'b1);
  assign done = inc && (cnt == target_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      use_x_q  <= 1'b0;
      cnt      <= '0;
      target_q <= '0;
    end else if (start) begin
      active   <= 1'b1;
      use_x_q  <= use_xtal;
      cnt      <= '0;
      target_q <= use_xtal ? (CNT_W'(1) << exp_sel) : CNT_W'(INT_WAIT);
    end else if (done) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (inc) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R7: the wait count never passes its target
  assert_no_overrun_R7: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt < target_q));

endmodule

// File: rtl/standby_osc_gate.sv
module standby_osc_gate
  import standby_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  sb_state_t  state_nx,
  input  logic       run_hx_on,
  input  logic       run_hi_on,
  input  logic       run_sub_on,
  input  logic       lsosc_keep,
  input  logic       wake_xtal,
  output logic       cpu_clk_en,
  output logic       hxosc_en,
  output logic       hiosc_en,
  output logic       subosc_en,
  output logic       lsosc_en,
  output logic [1:0] mode_stat
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en <= 1'b1;
      hxosc_en   <= 1'b0;
      hiosc_en   <= 1'b1;
      subosc_en  <= 1'b0;
      lsosc_en   <= 1'b1;
      mode_stat  <= STAT_RUN;
    end else begin
      subosc_en <= run_sub_on;
      case (state_nx)
        ST_SLEEP: begin
          cpu_clk_en <= 1'b0;
          hxosc_en   <= run_hx_on;
          hiosc_en   <= run_hi_on;
          lsosc_en   <= lsosc_keep;
          mode_stat  <= STAT_SLEEP;
        end
        ST_DEEP: begin
          cpu_clk_en <= 1'b0;
          hxosc_en   <= 1'b0;
          hiosc_en   <= 1'b0;
          lsosc_en   <= lsosc_keep;
          mode_stat  <= STAT_DEEP;
        end
        ST_WAIT, ST_RESUME: begin
          cpu_clk_en <= (state_nx == ST_RESUME);
          hxosc_en   <= run_hx_on | wake_xtal;
          hiosc_en   <= run_hi_on | ~wake_xtal;
          lsosc_en   <= 1'b1;
          mode_stat  <= STAT_WAKE;
        end
        default: begin
          cpu_clk_en <= 1'b1;
          hxosc_en   <= run_hx_on;
          hiosc_en   <= run_hi_on;
          lsosc_en   <= 1'b1;
          mode_stat  <= STAT_RUN;
        end
      endcase
    end
  end

endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
  import standby_pkg::*;
#(
  parameter int IRQ_W    = 8,
  parameter int EXP_W    = 3,
  parameter int INT_WAIT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wfi_req,
  input  logic             deep_sel,
  input  logic             cpu_on_sub,
  input  logic             main_is_xtal,
  input  logic             lsosc_keep,
  input  logic [EXP_W-1:0] stab_exp,
  input  logic             run_hx_on,
  input  logic             run_hi_on,
  input  logic             run_sub_on,
  input  logic [IRQ_W-1:0] irq_req,
  input  logic [IRQ_W-1:0] irq_en,
  input  logic             xtal_tick,
  output logic             cpu_clk_en,
  output logic             hxosc_en,
  output logic             hiosc_en,
  output logic             subosc_en,
  output logic             lsosc_en,
  output logic [1:0]       mode_stat
);

  logic             wake_evt;
  sb_state_t        state;
  sb_state_t        state_nx;
  logic             wake_xtal_q;
  logic [EXP_W-1:0] exp_q;
  logic             timer_start;
  logic             wait_done;

  assign wake_evt = |(irq_req & irq_en);

  standby_fsm #(.EXP_W(EXP_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .wfi_req     (wfi_req),
    .deep_sel    (deep_sel),
    .cpu_on_sub  (cpu_on_sub),
    .main_is_xtal(main_is_xtal),
    .stab_exp    (stab_exp),
    .wake_evt    (wake_evt),
    .wait_done   (wait_done),
    .state       (state),
    .state_nx    (state_nx),
    .wake_xtal_q (wake_xtal_q),
    .exp_q       (exp_q),
    .timer_start (timer_start)
  );

  standby_stab_timer #(.EXP_W(EXP_W), .INT_WAIT(INT_WAIT)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (timer_start),
    .use_xtal (wake_xtal_q),
    .exp_sel  (exp_q),
    .xtal_tick(xtal_tick),
    .done     (wait_done)
  );

  standby_osc_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .state_nx  (state_nx),
    .run_hx_on (run_hx_on),
    .run_hi_on (run_hi_on),
    .run_sub_on(run_sub_on),
    .lsosc_keep(lsosc_keep),
    .wake_xtal (wake_xtal_q),
    .cpu_clk_en(cpu_clk_en),
    .hxosc_en  (hxosc_en),
    .hiosc_en  (hiosc_en),
    .subosc_en (subosc_en),
    .lsosc_en  (lsosc_en),
    .mode_stat (mode_stat)
  );

  // R2: sleep gates the CPU clock and reports 01
  assert_sleep_gated_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLEEP) |-> (!cpu_clk_en && mode_stat == STAT_SLEEP));

  // R3: deep sleep has both high-speed oscillators off
  assert_deep_hs_off_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DEEP) |-> (!cpu_clk_en && !hxosc_en && !hiosc_en));

  // R5: the low-speed oscillator follows the keep bit in standby
  assert_ls_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLEEP || state == ST_DEEP) |-> (lsosc_en == $past(lsosc_keep)));

  // R7: the CPU clock stays off through the stabilization wait
  assert_wait_gated_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> (!cpu_clk_en && mode_stat == STAT_WAKE));

endmodule

// File: tb/standby_ctrl_tb.sv
module standby_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IRQ_W      = 8;
  localparam int EXP_W      = 3;
  localparam int INT_WAIT   = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wfi_req = 1'b0, deep_sel = 1'b0, cpu_on_sub = 1'b0;
  logic             main_is_xtal = 1'b0, lsosc_keep = 1'b0;
  logic [EXP_W-1:0] stab_exp = '0;
  logic             run_hx_on = 1'b0, run_hi_on = 1'b1, run_sub_on = 1'b0;
  logic [IRQ_W-1:0] irq_req = '0, irq_en = '0;
  logic             xtal_tick = 1'b0;
  logic             cpu_clk_en, hxosc_en, hiosc_en, subosc_en, lsosc_en;
  logic [1:0]       mode_stat;

  int n_chk = 0, n_fail = 0, cyc_cnt = 0, tick_div = 1;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  standby_ctrl #(.IRQ_W(IRQ_W), .EXP_W(EXP_W), .INT_WAIT(INT_WAIT)) u_dut (
    .clk(clk), .rst(rst), .wfi_req(wfi_req), .deep_sel(deep_sel),
    .cpu_on_sub(cpu_on_sub), .main_is_xtal(main_is_xtal), .lsosc_keep(lsosc_keep),
    .stab_exp(stab_exp), .run_hx_on(run_hx_on), .run_hi_on(run_hi_on),
    .run_sub_on(run_sub_on), .irq_req(irq_req), .irq_en(irq_en), .xtal_tick(xtal_tick),
    .cpu_clk_en(cpu_clk_en), .hxosc_en(hxosc_en), .hiosc_en(hiosc_en),
    .subosc_en(subosc_en), .lsosc_en(lsosc_en), .mode_stat(mode_stat)
  );

  task automatic cyc();
    @(negedge clk);
    cyc_cnt++;
    xtal_tick = (tick_div > 0) && (cyc_cnt % tick_div == 0);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_run(input string req);
    chk({req, " run status"}, mode_stat, 0);
    chk({req, " run cpu clk"}, cpu_clk_en, 1);
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Wake from deep sleep; returns measured wait cycles, ticks, last-cycle tick
  task automatic deep_wake(output int w, output int t, output int last_t);
    w = 0; t = 0; last_t = 0;
    irq_req = 8'h10; irq_en = 8'h10;
    for (int k = 0; k < 2000; k++) begin
      cyc();
      if (mode_stat == 2'b11 && !cpu_clk_en) begin
        w++;
        last_t = xtal_tick;
        if (xtal_tick) t++;
        if (main_is_xtal_entry) chk("R7 crystal on in wait", hxosc_en, 1);
        else chk("R8 internal osc on in wait", hiosc_en, 1);
      end else break;
    end
    irq_req = '0; irq_en = '0;
  endtask

  logic main_is_xtal_entry = 1'b0;

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_up();
  end

  initial begin
    int w, t, lt;
    // R1 reset state
    cyc(); cyc();
    chk("R1 reset status", mode_stat, 0);
    chk("R1 reset cpu clk", cpu_clk_en, 1);
    chk("R1 reset ls", lsosc_en, 1);
    chk("R1 reset hi", hiosc_en, 1);
    chk("R1 reset hx", hxosc_en, 0);
    chk("R1 reset sub", subosc_en, 0);
    run_hx_on = 1; run_hi_on = 0; run_sub_on = 1;
    rst = 0;
    cyc();
    chk("R1 first cycle status", mode_stat, 0);
    chk("R1 first cycle hx", hxosc_en, 1);
    chk("R1 first cycle hi", hiosc_en, 0);
    chk("R1 first cycle sub", subosc_en, 1);

    // R2/R4/R5/R6 sweep through sleep
    for (int v = 0; v < 32; v++) begin
      run_hx_on = v[0]; run_hi_on = v[1]; run_sub_on = v[2];
      lsosc_keep = v[3]; cpu_on_sub = v[4]; deep_sel = v[4];
      cyc();
      wfi_req = 1;
      cyc();
      wfi_req = 0;
      chk(v[4] ? "R4 refused deep status" : "R2 sleep status", mode_stat, 1);
      chk("R2 sleep cpu gated", cpu_clk_en, 0);
      chk(v[4] ? "R4 hx kept" : "R2 hx kept", hxosc_en, v[0]);
      chk(v[4] ? "R4 hi kept" : "R2 hi kept", hiosc_en, v[1]);
      chk("R2 sub kept", subosc_en, v[2]);
      chk("R5 ls in sleep", lsosc_en, v[3]);
      irq_req = 8'h03; irq_en = 8'h0C;
      cyc(); cyc();
      chk("R6 masked irq ignored", mode_stat, 1);
      irq_en = 8'h02;
      cyc();
      chk("R6 resume status", mode_stat, 3);
      chk("R6 resume cpu clk", cpu_clk_en, 1);
      chk("R5 ls on in resume", lsosc_en, 1);
      irq_req = '0; irq_en = '0;
      cyc();
      chk_run("R6");
    end
    cpu_on_sub = 0;

    // R9 abort on coincident wake event
    for (int d = 0; d < 2; d++) begin
      deep_sel = d[0];
      wfi_req = 1; irq_req = 8'h80; irq_en = 8'hFF;
      cyc();
      wfi_req = 0; irq_req = '0; irq_en = '0;
      chk_run("R9 abort");
      cyc();
      chk_run("R9 abort settled");
    end

    // R3/R7/R8/R10 deep sleep sweep
    for (int m = 0; m < 2; m++)
      for (int e = 0; e < 8; e++)
        for (int dv = 0; dv < 2; dv++) begin
          tick_div = dv ? 3 : 1;
          main_is_xtal = m[0]; main_is_xtal_entry = m[0];
          run_hx_on = m[0]; run_hi_on = !m[0]; run_sub_on = e[0];
          lsosc_keep = e[1]; stab_exp = e[2:0]; deep_sel = 1;
          cyc();
          wfi_req = 1;
          cyc();
          wfi_req = 0;
          chk("R3 deep status", mode_stat, 2);
          chk("R3 deep cpu gated", cpu_clk_en, 0);
          chk("R3 deep hx off", hxosc_en, 0);
          chk("R3 deep hi off", hiosc_en, 0);
          chk("R3 deep sub follows", subosc_en, e[0]);
          chk("R5 ls in deep", lsosc_en, e[1]);
          // R10: disturb captured settings
          stab_exp = 3'(e + 3); main_is_xtal = !m[0];
          cyc(); cyc();
          deep_wake(w, t, lt);
          if (m[0]) begin
            chk("R7 ticks in wait (R10 held)", t, 1 << e);
            chk("R7 last wait cycle ticked", lt, 1);
            if (dv == 0) chk("R7 wait length", w, 1 << e);
          end else begin
            chk("R8 internal wait length (R10 held)", w, INT_WAIT);
          end
          chk("R7 resume status", mode_stat, 3);
          chk("R7 resume cpu clk", cpu_clk_en, 1);
          cyc();
          chk_run("R7 back to run");
        end

    finish_up();
  end
endmodule